// File: doc/BRIEF.md
# ADC Sample and Convert Sequencer

This block is the digital sequencer that sits beside a successive-approximation converter. Software programs a single 16-bit control word over a plain write/read register port. That word selects the resolution, the output number format, the event that closes the sampling window, and the idle behaviour. While the sample bit is set, the converter is sampling. When the chosen end-of-sample event arrives, the block clears the sample bit and sends a one-cycle conversion request to the external converter. It then waits for the converter's completion pulse.

On completion, the raw code is packed into a 16-bit word in one of four forms: unsigned or signed, right-justified or left-justified. The resolution decides the packing. The done bit is then set. If auto-sampling is enabled, a new sampling window opens at once. An internal counter can end each window after a fixed number of clocks, so that conversions repeat without software involvement.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While the enable bit (control bit 15) is 0, `conv_start` never pulses.
- R2: With the idle-stop bit (bit 13) set and `idle_i` high, no conversion starts. With bit 13 clear, `idle_i` has no effect.
- R3: Trigger select field bits 7:5 picks the end-of-sample event: 001 a rising edge of `ext_int_i`, 010 `tmr_a_evt_i`, 011 `pwm1_evt_i`, 100 `tmr_b_evt_i`, 101 `pwm2_evt_i`. An event from an unselected source starts nothing.
- R4: With trigger code 000, a register write that clears the sample bit (bit 1) while it is set starts a conversion.
- R5: With trigger code 111, `conv_start` rises exactly SAMP_CYC clock cycles (default 15) after the sample bit becomes 1.
- R6: Trigger code 110 is reserved. No source starts a conversion under it.
- R7: The result depends on format field bits 9:8 and resolution bit 10 (1 = 12-bit, 0 = 10-bit), with N data bits d:
  - 00: d zero-extended.
  - 01: d minus 2^(N-1), sign-extended.
  - 10: d shifted left by 16-N.
  - 11: (d minus 2^(N-1)) mod 2^N, shifted left by 16-N.
- R8: After reset the control word reads 0x0000. Bits 14, 12, 11, 4 and 3 always read 0.
- R9: The done bit (bit 0) sets on conversion completion. Writing 1 to it leaves it unchanged, and writing 0 clears it.
- R10: On completion, the sample bit becomes 1 if the auto-sample bit (bit 2) is set and stays 0 otherwise. Starting a conversion clears the sample bit.
- R11: `conv_start` is a single-cycle pulse. Trigger events that arrive during a conversion are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read value |
| idle_i | input | 1 | System idle indication |
| ext_int_i | input | 1 | External interrupt level, rising edge is the event |
| tmr_a_evt_i | input | 1 | Timer A compare pulse |
| pwm1_evt_i | input | 1 | PWM 1 interval pulse |
| tmr_b_evt_i | input | 1 | Timer B compare pulse |
| pwm2_evt_i | input | 1 | PWM 2 interval pulse |
| conv_start | output | 1 | One-cycle conversion request |
| conv_done_i | input | 1 | Converter completion pulse |
| raw_result_i | input | 12 | Raw converter code, valid with conv_done_i |
| result_o | output | 16 | Formatted result of last conversion |

## Verification
The assertions assume the following about the converter:
- It raises `conv_done_i` only while a conversion is outstanding.
- It holds `conv_done_i` high for one cycle.
- It presents `raw_result_i` in that same cycle.
- The timer and PWM event inputs are single-cycle pulses.

The bench's converter model answers each request after a fixed latency with exactly one completion pulse. Events are driven as one-cycle pulses. Register writes and event pulses are issued on the falling edge, so they never coincide ambiguously with a completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CTRL_W = 16;
  localparam int RAW_W  = 12;

  // control bit positions
  localparam int B_EN   = 15;
  localparam int B_SIDL = 13;
  localparam int B_RES  = 10;
  localparam int B_FMT  = 8;
  localparam int B_TRG  = 5;
  localparam int B_ASAM = 2;
  localparam int B_SAMP = 1;
  localparam int B_DONE = 0;

  typedef enum logic [2:0] {
    TRG_SWCLR = 3'd0,
    TRG_EXT   = 3'd1,
    TRG_TMRA  = 3'd2,
    TRG_PWM1  = 3'd3,
    TRG_TMRB  = 3'd4,
    TRG_PWM2  = 3'd5,
    TRG_RSVD  = 3'd6,
    TRG_AUTO  = 3'd7
  } trig_e;

  typedef enum logic [1:0] {
    FMT_UINT  = 2'd0,
    FMT_SINT  = 2'd1,
    FMT_UFRAC = 2'd2,
    FMT_SFRAC = 2'd3
  } fmt_e;

  // Packs a raw code: signed forms flip the data MSB (offset binary to two's complement)
  function automatic logic [CTRL_W-1:0] pack_result(input logic [RAW_W-1:0] raw,
                                                    input logic res12,
                                                    input logic [1:0] fmt);
    logic [RAW_W-1:0] flip;
    logic [CTRL_W-1:0] r;
    flip = raw ^ (res12 ? 12'h800 : 12'h200);
    case (fmt_e'(fmt))
      FMT_UINT:  r = res12 ? {4'b0, raw} : {6'b0, raw[9:0]};
      FMT_SINT:  r = res12 ? {{4{flip[11]}}, flip} : {{6{flip[9]}}, flip[9:0]};
      FMT_UFRAC: r = res12 ? {raw, 4'b0} : {raw[9:0], 6'b0};
      default:   r = res12 ? {flip, 4'b0} : {flip[9:0], 6'b0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] trig_sel,
  input  logic       sw_clr_evt,
  input  logic       ext_int_i,
  input  logic       tmr_a_evt_i,
  input  logic       pwm1_evt_i,
  input  logic       tmr_b_evt_i,
  input  logic       pwm2_evt_i,
  input  logic       auto_fire,
  output logic       end_samp
);
  logic ext_q;
  logic ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_int_i;
  end

  assign ext_rise = ext_int_i & ~ext_q;

  always_comb begin
    case (trig_e'(trig_sel))
      TRG_SWCLR: end_samp = sw_clr_evt;
      TRG_EXT:   end_samp = ext_rise;
      TRG_TMRA:  end_samp = tmr_a_evt_i;
      TRG_PWM1:  end_samp = pwm1_evt_i;
      TRG_TMRB:  end_samp = tmr_b_evt_i;
      TRG_PWM2:  end_samp = pwm2_evt_i;
      TRG_AUTO:  end_samp = auto_fire;
      default:   end_samp = 1'b0;
    endcase
  end

  // R6: reserved code never yields an end-of-sample event
  a_r6_rsvd_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == TRG_RSVD) |-> !end_samp);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int SAMP_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic samp,
  input  logic end_samp,
  input  logic conv_done_i,
  output logic auto_fire,
  output logic start_evt,
  output logic conv_cmplt,
  output logic busy_o,
  output logic conv_start_o
);
  localparam int CNT_W = (SAMP_CYC < 2) ? 1 : $clog2(SAMP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMP_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             busy_q;
  logic             start_q;

  assign auto_fire  = samp & ~busy_q & active & (cnt == CNT_LAST);
  assign start_evt  = end_samp & samp & ~busy_q & active;
  assign conv_cmplt = busy_q & conv_done_i;
  assign busy_o       = busy_q;
  assign conv_start_o = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_evt;
      if (start_evt)       busy_q <= 1'b1;
      else if (conv_cmplt) busy_q <= 1'b0;
      if (!samp || busy_q || !active || start_evt) cnt <= '0;
      else if (cnt != CNT_LAST)                    cnt <= cnt + 1'b1;
    end
  end

  // R11: request lasts one cycle
  a_r11_one_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);
  // R11: no new request while a conversion is outstanding
  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !conv_done_i) |=> !conv_start_o);
  // R5: sample counter stays within its window
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LAST);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SAMP_CYC = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        idle_i,
  input  logic        ext_int_i,
  input  logic        tmr_a_evt_i,
  input  logic        pwm1_evt_i,
  input  logic        tmr_b_evt_i,
  input  logic        pwm2_evt_i,
  output logic        conv_start,
  input  logic        conv_done_i,
  input  logic [11:0] raw_result_i,
  output logic [15:0] result_o
);
  logic       en_q, sidl_q, res12_q, asam_q, samp_q, done_q;
  logic [1:0] fmt_q;
  logic [2:0] trig_q;
  logic [15:0] result_q;

  logic active, sw_clr, end_samp, auto_fire, start_evt, conv_cmplt, busy;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[14], reg_wdata[12], reg_wdata[11],
                          reg_wdata[4], reg_wdata[3], busy};

  assign active = en_q & ~(sidl_q & idle_i);
  assign sw_clr = reg_we & samp_q & ~reg_wdata[B_SAMP];

  adc_trig_sel u_trig (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_q), .sw_clr_evt(sw_clr),
    .ext_int_i(ext_int_i), .tmr_a_evt_i(tmr_a_evt_i), .pwm1_evt_i(pwm1_evt_i),
    .tmr_b_evt_i(tmr_b_evt_i), .pwm2_evt_i(pwm2_evt_i),
    .auto_fire(auto_fire), .end_samp(end_samp)
  );

  adc_seq_fsm #(.SAMP_CYC(SAMP_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .active(active), .samp(samp_q),
    .end_samp(end_samp), .conv_done_i(conv_done_i), .auto_fire(auto_fire),
    .start_evt(start_evt), .conv_cmplt(conv_cmplt), .busy_o(busy),
    .conv_start_o(conv_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; sidl_q <= 1'b0; res12_q <= 1'b0; asam_q <= 1'b0;
      samp_q <= 1'b0; done_q <= 1'b0; fmt_q <= '0; trig_q <= '0;
      result_q <= '0;
    end else begin
      if (reg_we) begin
        en_q    <= reg_wdata[B_EN];
        sidl_q  <= reg_wdata[B_SIDL];
        res12_q <= reg_wdata[B_RES];
        fmt_q   <= reg_wdata[B_FMT +: 2];
        trig_q  <= reg_wdata[B_TRG +: 3];
        asam_q  <= reg_wdata[B_ASAM];
        samp_q  <= reg_wdata[B_SAMP];
        if (!reg_wdata[B_DONE]) done_q <= 1'b0;
      end
      if (start_evt) samp_q <= 1'b0;
      if (conv_cmplt) begin
        done_q   <= 1'b1;
        result_q <= pack_result(raw_result_i, res12_q, fmt_q);
        if (asam_q) samp_q <= 1'b1;
      end
    end
  end

  assign reg_rdata = {en_q, 1'b0, sidl_q, 2'b00, res12_q, fmt_q, trig_q,
                      2'b00, asam_q, samp_q, done_q};
  assign result_o  = result_q;

  // R1/R2: an inactive block issues no request
  a_r1_inactive_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !conv_start);
  // R9: completion raises done
  a_r9_done_on_cmplt: assert property (@(posedge clk) disable iff (!rst_n)
    conv_cmplt |=> reg_rdata[B_DONE]);
  // R10: auto-sample reopens sampling after completion
  a_r10_asam_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_cmplt && asam_q && !reg_we) |=> reg_rdata[B_SAMP]);
  // R10: a request leaves sampling closed
  a_r10_start_clears_samp: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !reg_rdata[B_SAMP] || $past(reg_we));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CONV_LAT = 8;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        idle_i = 0, ext_int_i = 0;
  logic        tmr_a = 0, pwm1 = 0, tmr_b = 0, pwm2 = 0;
  logic        conv_start, conv_done = 0;
  logic [11:0] raw = '0, next_raw = '0;
  logic [15:0] result_o;

  int total = 0, bad = 0, n_start = 0;
  logic done_prev = 0;
  logic [15:0] exp_q[$];

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .idle_i(idle_i), .ext_int_i(ext_int_i),
    .tmr_a_evt_i(tmr_a), .pwm1_evt_i(pwm1), .tmr_b_evt_i(tmr_b),
    .pwm2_evt_i(pwm2), .conv_start(conv_start), .conv_done_i(conv_done),
    .raw_result_i(raw), .result_o(result_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input bit en, input bit sidl, input bit res,
      input logic [1:0] fmt, input logic [2:0] trg, input bit asam, input bit samp,
      input bit done);
    return {en, 1'b0, sidl, 2'b00, res, fmt, trg, 2'b00, asam, samp, done};
  endfunction

  function automatic logic [15:0] expf(input bit res, input logic [1:0] fmt,
                                       input logic [11:0] r);
    int n, full, d, s;
    n = res ? 12 : 10;
    full = 1 << n;
    d = int'(r) % full;
    s = d - full / 2;
    case (fmt)
      2'd0: return 16'(d);
      2'd1: return 16'(s);
      2'd2: return 16'(d << (16 - n));
      default: return 16'(((s + full) % full) << (16 - n));
    endcase
  endfunction

  task automatic wr(input logic [15:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (reg_rdata[0]) begin seen = 1; break; end
    end
    chk(seen, req, 0, 1);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] code);
    @(negedge clk);
    case (code)
      3'd1: ext_int_i = 1;
      3'd2: tmr_a = 1;
      3'd3: pwm1 = 1;
      3'd4: tmr_b = 1;
      3'd5: pwm2 = 1;
      default: ;
    endcase
    @(negedge clk);
    ext_int_i = 0; tmr_a = 0; pwm1 = 0; tmr_b = 0; pwm2 = 0;
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        repeat (CONV_LAT - 1) @(negedge clk);
        conv_done = 1; raw = next_raw;
        @(negedge clk);
        conv_done = 0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start) n_start++;
      if (reg_rdata[0] && !done_prev) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected completion", result_o, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(result_o == e, "R7 result format", result_o, e);
        end
      end
      done_prev = reg_rdata[0];
    end
  end

  task automatic manual_conv(input bit res, input logic [1:0] fmt, input logic [11:0] r);
    next_raw = r;
    exp_q.push_back(expf(res, fmt, r));
    wr(cw(1, 0, res, fmt, 3'd0, 0, 1, 0));
    wr(cw(1, 0, res, fmt, 3'd0, 0, 0, 0));   // R4: clearing sample ends it
    wait_done("R4 sw-clear conversion");
    wr(cw(1, 0, res, fmt, 3'd0, 0, 0, 0));
  endtask

  task automatic trig_conv(input logic [2:0] code, input logic [2:0] wrong, input logic [11:0] r);
    int s0;
    wr(cw(1, 0, 0, 2'd0, code, 0, 1, 0));
    s0 = n_start;
    pulse(wrong);
    idle_cycles(4);
    chk(n_start == s0, "R3 unselected source ignored", n_start - s0, 0);
    next_raw = r;
    exp_q.push_back(expf(0, 2'd0, r));
    pulse(code);
    wait_done("R3 selected source starts");
    chk(n_start == s0 + 1, "R3 one start", n_start - s0, 1);
    wr(cw(0, 0, 0, 2'd0, 3'd0, 0, 0, 0));
  endtask

  initial begin : watchdog
    #(200_000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reg_rdata == 16'h0000, "R8 reset value", reg_rdata, 0);
    chk(!conv_start && result_o == 0, "R8 reset outputs", result_o, 0);

    // R8: unimplemented bits read zero, R1 disabled block idle
    s0 = n_start;
    wr(16'h7FFF);
    chk(reg_rdata == 16'h27E6, "R8 unimplemented bits zero", reg_rdata, 16'h27E6);
    idle_cycles(30);
    chk(n_start == s0, "R1 disabled no start", n_start - s0, 0);
    wr(16'h0000);

    // R7: all formats, both resolutions
    manual_conv(0, 2'd0, 12'h2B7);
    manual_conv(0, 2'd1, 12'h0A5);
    manual_conv(0, 2'd1, 12'h3F0);
    manual_conv(0, 2'd2, 12'h155);
    manual_conv(0, 2'd3, 12'h101);
    manual_conv(1, 2'd0, 12'hABC);
    manual_conv(1, 2'd1, 12'h123);
    manual_conv(1, 2'd1, 12'hFFF);
    manual_conv(1, 2'd2, 12'h5A5);
    manual_conv(1, 2'd3, 12'h800);

    // R9: write 1 to done keeps it, write 0 clears
    next_raw = 12'h011;
    exp_q.push_back(expf(0, 2'd0, 12'h011));
    wr(cw(1, 0, 0, 2'd0, 3'd0, 0, 1, 0));
    wr(cw(1, 0, 0, 2'd0, 3'd0, 0, 0, 0));
    wait_done("R9 done set");
    wr(cw(1, 0, 0, 2'd0, 3'd0, 0, 0, 1));
    chk(reg_rdata[0] == 1, "R9 write one no effect", reg_rdata[0], 1);
    wr(cw(1, 0, 0, 2'd0, 3'd0, 0, 0, 0));
    chk(reg_rdata[0] == 0, "R9 write zero clears", reg_rdata[0], 0);

    // R3: each selectable source
    trig_conv(3'd1, 3'd2, 12'h021);
    trig_conv(3'd2, 3'd3, 12'h032);
    trig_conv(3'd3, 3'd4, 12'h043);
    trig_conv(3'd4, 3'd5, 12'h054);
    trig_conv(3'd5, 3'd1, 12'h065);

    // R6: reserved code
    s0 = n_start;
    wr(cw(1, 0, 0, 2'd0, 3'd6, 0, 1, 0));
    for (int c = 1; c <= 5; c++) pulse(3'(c));
    idle_cycles(30);
    chk(n_start == s0, "R6 reserved no start", n_start - s0, 0);
    wr(16'h0000);

    // R5: auto counter timing, R10 sample stays clear without auto-sample
    next_raw = 12'h3AA;
    exp_q.push_back(expf(0, 2'd0, 12'h3AA));
    wr(cw(1, 0, 0, 2'd0, 3'd7, 0, 1, 0));
    k = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (conv_start) begin k = i; break; end
    end
    chk(k == 15, "R5 auto start delay", k, 15);
    chk(reg_rdata[1] == 0, "R10 start clears sample", reg_rdata[1], 0);
    wait_done("R5 auto conversion");
    chk(reg_rdata[1] == 0, "R10 no restart without auto-sample", reg_rdata[1], 0);
    wr(16'h0000);

    // R10: auto-sample restarts sampling
    next_raw = 12'h155;
    exp_q.push_back(expf(0, 2'd0, 12'h155));
    wr(cw(1, 0, 0, 2'd0, 3'd7, 1, 1, 0));
    wait_done("R10 auto-sample conversion");
    chk(reg_rdata[1] == 1, "R10 sample restarted", reg_rdata[1], 1);
    wr(16'h0000);

    // R11: events during conversion ignored
    s0 = n_start;
    next_raw = 12'h0F0;
    exp_q.push_back(expf(0, 2'd0, 12'h0F0));
    wr(cw(1, 0, 0, 2'd0, 3'd1, 0, 1, 0));
    pulse(3'd1);
    wr(cw(1, 0, 0, 2'd0, 3'd1, 0, 1, 0));
    pulse(3'd1);
    wait_done("R11 busy conversion");
    idle_cycles(4);
    chk(n_start == s0 + 1, "R11 busy ignores events", n_start - s0, 1);
    wr(16'h0000);

    // R2: idle stop
    s0 = n_start;
    idle_i = 1;
    wr(cw(1, 1, 0, 2'd0, 3'd7, 0, 1, 0));
    idle_cycles(40);
    chk(n_start == s0, "R2 idle stop holds", n_start - s0, 0);
    next_raw = 12'h2A2;
    exp_q.push_back(expf(0, 2'd0, 12'h2A2));
    idle_i = 0;
    wait_done("R2 resumes after idle");
    wr(16'h0000);
    s0 = n_start;
    idle_i = 1;
    next_raw = 12'h1C3;
    exp_q.push_back(expf(0, 2'd0, 12'h1C3));
    wr(cw(1, 0, 0, 2'd0, 3'd7, 0, 1, 0));
    wait_done("R2 idle ignored when stop bit clear");
    chk(n_start == s0 + 1, "R2 run during idle", n_start - s0, 1);
    idle_i = 0;
    wr(16'h0000);

    chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule